// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a single-cycle 32-bit processor and decides each cycle where execution goes next. It receives the opcode and the remaining 26 bits of the current instruction together with the two register operands that the register file read for it. From these it chooses the next address. The choices are:

- the following word;
- a PC-relative branch, taken on operand equality, on inequality, or on a signed comparison of the first operand with zero;
- an absolute jump inside the current 256 MiB region;
- a jump that also saves a return address;
- a jump to an address held in a register.

For the jump that saves a return address, the block raises a write request toward the register file. The request carries the link register index and the address two words past the current instruction.

Instructions that do not affect control flow advance the counter by one word, so the rest of the core can present every instruction to the block without filtering. The counter register is updated on each rising clock edge. A synchronous reset returns it to the reset address.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` takes the reset address (0x00000000 by default) at that edge.
- R2: Any opcode not listed below gives `next_pc = pc + 4`. Two cases of listed opcodes also give `pc + 4`: opcode 0x00 with a funct (`ins_body[5:0]`) other than 0x08, and opcode 0x01 with a sub-op (`ins_body[20:16]`) other than 0 or 1.
- R3: Opcode 0x04 branches when `rs_val == rt_val`. The target is `pc + 4 + (sign-extended ins_body[15:0] << 2)`; when not taken, `next_pc = pc + 4`.
- R4: Opcode 0x05 branches to the same target when `rs_val != rt_val`.
- R5: Opcode 0x01 with sub-op 0 branches when `rs_val` is negative as a signed value. With sub-op 1 it branches when `rs_val` is zero or positive. Both use the branch target of R3.
- R6: Opcode 0x06 branches when `rs_val` is signed less than or equal to zero. Opcode 0x07 branches when it is signed greater than zero. The sub-op field is ignored for both.
- R7: Opcode 0x02 gives `next_pc = {(pc+4)[31:28], ins_body[25:0], 2'b00}`.
- R8: Opcode 0x03 jumps like R7 and asserts `link_we`, with `link_idx = 31` and `link_val = pc + 8`.
- R9: Opcode 0x00 with funct 0x08 gives `next_pc = rs_val`, unaligned values included.
- R10: `link_we` is low for every instruction except opcode 0x03.
- R11: Outside reset, `pc` takes the value `next_pc` had before each rising edge. All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ins_op | input | 6 | Instruction opcode field (bits 31:26) |
| ins_body | input | 26 | Instruction bits 25:0 (register fields, immediate, funct, jump field) |
| rs_val | input | 32 | First register operand |
| rt_val | input | 32 | Second register operand |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address loaded into `pc` at the next edge |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Destination register index for the link write |
| link_val | output | 32 | Return address to be written |

## Verification
The bench builds the block twice at the default 32-bit width. One instance uses the sign-bit comparator and the other uses the arithmetic signed comparator, so both generate variants are compared against the same arithmetic model on every instruction. Before each swept instruction, a register jump moves the counter to a chosen base. The bases include an address one word below the top of the address space, which exercises wrap-around, and an address just under a 256 MiB region boundary, which exposes the region bits of the jump target. All 64 opcodes are crossed with:

- sub-op values inside and outside the defined set;
- positive, negative and funct-matching offsets;
- operand values at zero, at ±1 and at the signed extremes.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_ZCMP    = 6'h01;
   localparam logic [5:0] OP_JUMP    = 6'h02;
   localparam logic [5:0] OP_JLINK   = 6'h03;
   localparam logic [5:0] OP_BREQ    = 6'h04;
   localparam logic [5:0] OP_BRNE    = 6'h05;
   localparam logic [5:0] OP_BRLEZ   = 6'h06;
   localparam logic [5:0] OP_BRGTZ   = 6'h07;
   localparam logic [5:0] FN_JREG    = 6'h08;
   localparam logic [4:0] SUB_LTZ    = 5'd0;
   localparam logic [4:0] SUB_GEZ    = 5'd1;

   typedef enum logic [2:0] {
      FLOW_SEQ,
      FLOW_BR,
      FLOW_JMP,
      FLOW_JAL,
      FLOW_JREG
   } flow_e;

   typedef enum logic [2:0] {
      BC_EQ,
      BC_NE,
      BC_LTZ,
      BC_GEZ,
      BC_LEZ,
      BC_GTZ
   } bcond_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [5:0] op,
   input  logic [4:0] subop,
   input  logic [5:0] funct,
   output flow_e      flow,
   output bcond_e     cond
);

   always_comb begin
      flow = FLOW_SEQ;
      cond = BC_EQ;
      case (op)
         OP_SPECIAL: if (funct == FN_JREG) flow = FLOW_JREG;
         OP_ZCMP: begin
            if (subop == SUB_LTZ) begin
               flow = FLOW_BR;
               cond = BC_LTZ;
            end else if (subop == SUB_GEZ) begin
               flow = FLOW_BR;
               cond = BC_GEZ;
            end
         end
         OP_JUMP:  flow = FLOW_JMP;
         OP_JLINK: flow = FLOW_JAL;
         OP_BREQ: begin
            flow = FLOW_BR;
            cond = BC_EQ;
         end
         OP_BRNE: begin
            flow = FLOW_BR;
            cond = BC_NE;
         end
         OP_BRLEZ: begin
            flow = FLOW_BR;
            cond = BC_LEZ;
         end
         OP_BRGTZ: begin
            flow = FLOW_BR;
            cond = BC_GTZ;
         end
         default: flow = FLOW_SEQ;
      endcase
   end

endmodule

// File: rtl/npc_branch_cmp.sv
module npc_branch_cmp
   import npc_pkg::*;
#(
   parameter int W            = 32,
   parameter bit CMP_VIA_SIGN = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  bcond_e       cond,
   output logic         taken
);

   logic eq, neg, zero;

   assign eq = (a == b);

   generate
      if (CMP_VIA_SIGN) begin : g_sign
         assign neg  = a[W-1];
         assign zero = ~|a;
      end else begin : g_arith
         assign neg  = ($signed(a) < $signed({W{1'b0}}));
         assign zero = ($signed(a) == $signed({W{1'b0}}));
      end
   endgenerate

   always_comb begin
      case (cond)
         BC_EQ:   taken = eq;
         BC_NE:   taken = !eq;
         BC_LTZ:  taken = neg;
         BC_GEZ:  taken = !neg;
         BC_LEZ:  taken = neg || zero;
         BC_GTZ:  taken = !neg && !zero;
         default: taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc,
   input  logic [25:0]     body,
   output logic [XLEN-1:0] seq,
   output logic [XLEN-1:0] br_tgt,
   output logic [XLEN-1:0] jmp_tgt,
   output logic [XLEN-1:0] link
);

   localparam int EXT_W    = XLEN - 18;
   localparam int REGION_W = XLEN - 28;

   logic [XLEN-1:0] offset;

   assign seq     = pc + XLEN'(4);
   assign link    = pc + XLEN'(8);
   assign offset  = {{EXT_W{body[15]}}, body[15:0], 2'b00};
   assign br_tgt  = seq + offset;
   assign jmp_tgt = {seq[XLEN-1 -: REGION_W], body, 2'b00};

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int          XLEN         = 32,
   parameter logic [31:0] RESET_PC     = 32'h0000_0000,
   parameter int          LINK_REG     = 31,
   parameter bit          CMP_VIA_SIGN = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [5:0]      ins_op,
   input  logic [25:0]     ins_body,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] next_pc,
   output logic            link_we,
   output logic [4:0]      link_idx,
   output logic [XLEN-1:0] link_val
);

   generate
      if (XLEN < 29) begin : g_bad_xlen
         $error("npc_unit: XLEN must leave room for the jump region bits");
      end
      if (LINK_REG < 0 || LINK_REG > 31) begin : g_bad_link
         $error("npc_unit: LINK_REG must index one of 32 registers");
      end
   endgenerate

   flow_e           flow;
   bcond_e          cond;
   logic            taken;
   logic [XLEN-1:0] seq, br_tgt, jmp_tgt, link;

   npc_decode u_dec (
      .op    (ins_op),
      .subop (ins_body[20:16]),
      .funct (ins_body[5:0]),
      .flow  (flow),
      .cond  (cond)
   );

   npc_branch_cmp #(.W(XLEN), .CMP_VIA_SIGN(CMP_VIA_SIGN)) u_cmp (
      .a     (rs_val),
      .b     (rt_val),
      .cond  (cond),
      .taken (taken)
   );

   npc_target #(.XLEN(XLEN)) u_tgt (
      .pc      (pc),
      .body    (ins_body),
      .seq     (seq),
      .br_tgt  (br_tgt),
      .jmp_tgt (jmp_tgt),
      .link    (link)
   );

   always_comb begin
      case (flow)
         FLOW_BR:   next_pc = taken ? br_tgt : seq;
         FLOW_JMP,
         FLOW_JAL:  next_pc = jmp_tgt;
         FLOW_JREG: next_pc = rs_val;
         default:   next_pc = seq;
      endcase
   end

   assign link_we  = (flow == FLOW_JAL);
   assign link_idx = 5'(LINK_REG);
   assign link_val = link;

   always_ff @(posedge clk) begin
      if (rst) pc <= XLEN'(RESET_PC);
      else     pc <= next_pc;
   end

   // R1
   a_r1_reset_pc: assert property (@(posedge clk)
      rst |=> pc == XLEN'(RESET_PC));

   // R11
   a_r11_pc_follows: assert property (@(posedge clk) disable iff (rst)
      !rst |=> pc == $past(next_pc));

   // R10
   a_r10_link_only_jal: assert property (@(posedge clk) disable iff (rst)
      link_we |-> ins_op == OP_JLINK);

   // R8
   a_r8_link_fields: assert property (@(posedge clk) disable iff (rst)
      link_we |-> (link_val == pc + XLEN'(8)) && (link_idx == 5'(LINK_REG))
                  && (next_pc[1:0] == 2'b00));

   // R9
   a_r9_jreg: assert property (@(posedge clk) disable iff (rst)
      (ins_op == OP_SPECIAL && ins_body[5:0] == FN_JREG) |-> next_pc == rs_val);

   // R2
   a_r2_seq: assert property (@(posedge clk) disable iff (rst)
      (ins_op > OP_BRGTZ) |-> next_pc == pc + XLEN'(4));

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [5:0]  ins_op = '0;
   logic [25:0] ins_body = '0;
   logic [31:0] rs_val = '0, rt_val = '0;
   logic [31:0] pc_a, npc_a, lval_a, pc_b, npc_b, lval_b;
   logic        we_a, we_b;
   logic [4:0]  lidx_a, lidx_b;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [31:0] cur_pc = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   npc_unit #(.CMP_VIA_SIGN(1'b1)) uut (
      .clk(clk), .rst(rst), .ins_op(ins_op), .ins_body(ins_body),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc_a), .next_pc(npc_a),
      .link_we(we_a), .link_idx(lidx_a), .link_val(lval_a));

   npc_unit #(.CMP_VIA_SIGN(1'b0)) uut_b (
      .clk(clk), .rst(rst), .ins_op(ins_op), .ins_body(ins_body),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc_b), .next_pc(npc_b),
      .link_we(we_b), .link_idx(lidx_b), .link_val(lval_b));

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [31:0] p, input logic [5:0] op,
                                 input logic [25:0] body, input logic [31:0] a,
                                 input logic [31:0] b, output logic [31:0] nxt,
                                 output logic we, output string tag);
      logic [31:0] p4, br, jt;
      p4  = p + 32'd4;
      br  = p4 + {{14{body[15]}}, body[15:0], 2'b00};
      jt  = {p4[31:28], body, 2'b00};
      nxt = p4;
      we  = 1'b0;
      tag = "R2";
      case (op)
         6'h00: if (body[5:0] == 6'h08) begin nxt = a; tag = "R9"; end
         6'h01: begin
            if (body[20:16] == 5'd0) begin
               tag = "R5"; if ($signed(a) < 0) nxt = br;
            end else if (body[20:16] == 5'd1) begin
               tag = "R5"; if ($signed(a) >= 0) nxt = br;
            end
         end
         6'h02: begin nxt = jt; tag = "R7"; end
         6'h03: begin nxt = jt; we = 1'b1; tag = "R8"; end
         6'h04: begin tag = "R3"; if (a == b) nxt = br; end
         6'h05: begin tag = "R4"; if (a != b) nxt = br; end
         6'h06: begin tag = "R6"; if ($signed(a) <= 0) nxt = br; end
         6'h07: begin tag = "R6"; if ($signed(a) > 0) nxt = br; end
         default: ;
      endcase
   endfunction

   // drive at posedge+1, check combinational outputs mid-cycle, check pc after the edge
   task automatic step(input logic [5:0] op, input logic [25:0] body,
                       input logic [31:0] a, input logic [31:0] b);
      logic [31:0] nxt;
      logic        we;
      string       tag;
      model(cur_pc, op, body, a, b, nxt, we, tag);
      ins_op = op; ins_body = body; rs_val = a; rt_val = b;
      #3;
      check(tag, "next_pc", npc_a, nxt);
      check(tag, "next_pc alt", npc_b, nxt);
      check("R10", "link_we", {31'd0, we_a}, {31'd0, we});
      check("R10", "link_we alt", {31'd0, we_b}, {31'd0, we});
      if (we) begin
         check("R8", "link_val", lval_a, cur_pc + 32'd8);
         check("R8", "link_idx", {27'd0, lidx_a}, 32'd31);
      end
      @(posedge clk); #1;
      check("R11", "pc", pc_a, nxt);
      check("R11", "pc alt", pc_b, nxt);
      cur_pc = nxt;
   endtask

   function automatic logic [31:0] opnd(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'hFFFF_FFFF;
         3: return 32'h7FFF_FFFF;
         4: return 32'h8000_0000;
         default: return 32'h0000_0040;
      endcase
   endfunction

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [31:0] bases [3];
      logic [15:0] imms  [3];
      logic [4:0]  subs  [3];
      bases[0] = 32'h0000_0100; bases[1] = 32'hFFFF_FFF8; bases[2] = 32'h2FFF_FFF8;
      imms[0]  = 16'h0008;      imms[1]  = 16'hFFF8;      imms[2]  = 16'h7FFF;
      subs[0]  = 5'd0;          subs[1]  = 5'd1;          subs[2]  = 5'd17;

      rst = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R1", "pc after reset", pc_a, 32'h0);
      check("R1", "pc after reset alt", pc_b, 32'h0);
      cur_pc = 32'h0;
      rst = 1'b0;

      // R2: plain sequential flow from reset
      step(6'h09, 26'h0, 32'h0, 32'h0);
      step(6'h23, 26'h0, 32'h0, 32'h0);

      for (int bi = 0; bi < 3; bi++)
         for (int op = 0; op < 64; op++)
            for (int ii = 0; ii < 3; ii++)
               for (int si = 0; si < 3; si++)
                  for (int vi = 0; vi < 6; vi++)
                     for (int eq = 0; eq < 2; eq++) begin
                        step(6'h00, {5'd1, 5'd0, 5'd0, 5'd0, 6'h08}, bases[bi], 32'h0);
                        step(6'(op), {5'd3, subs[si], imms[ii]}, opnd(vi),
                             (eq == 1) ? opnd(vi) : (opnd(vi) ^ 32'h1));
                     end

      // R1: reset mid-run overrides a pending jump-and-link
      ins_op = 6'h03; ins_body = 26'h3FF_FFFF; rst = 1'b1;
      @(posedge clk); #1;
      check("R1", "pc after mid-run reset", pc_a, 32'h0);
      check("R1", "pc after mid-run reset alt", pc_b, 32'h0);
      rst = 1'b0;
      cur_pc = 32'h0;
      step(6'h03, 26'h000_0010, 32'h0, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule